// File: doc/BRIEF.md
# Two-Pass Resampling Address Sequencer (Horizontal Pass)

This block produces the source-pixel addresses for the horizontal first pass of a separable image resampler. Each output pixel is built from a short run of source pixels, called a walk. On every clock of a walk the sequencer emits a source X/Y address, the filter tap index that selects the coefficient, and the output coordinates u/v of the pixel under construction. Flags mark where the accumulator restarts and where walks, lines and the frame end.

Setup goes through a small register write port. The registers hold a signed start point, a signed step applied between walks (du) and between lines (dv), signed second-order terms that make those steps change as the pass proceeds, the kernel length, the pixel stride inside a walk, an operating mode, and the output coordinate ranges. A one-cycle start pulse runs one frame. The sequencer then stops until the next pulse. Pixel storage, the multiply-accumulate datapath and the vertical pass sit outside this block.

Top module: `rs_resample_seq`

## Requirements
- R1: After reset, and whenever no frame is running, `addr_vld`, `init`, `acc`, `end_x`, `end_y` and `done` are all 0.
- R2: Control register 10 holds the mode in bits [1:0]. A start pulse while idle with mode 2'b01 makes the next cycle show the first pixel: X = x0 (register 0), Y = y0 (register 1), coefficient 0, u = umin (register 11), v = vmin (register 13), with `addr_vld` and `init` high.
- R3: The kernel length is K = field + 1, where the field is register 10 bits [5:2]. Inside a walk the coefficient address counts 0 to K-1, X advances each cycle by the unsigned stride in register 10 bits [8:6], and Y stays put.
- R4: After the last tap of a walk that is not the last walk of its line, the next address is the current X plus the X walk step and the current Y plus the Y walk step. The walk steps start at registers 2 and 3, and u rises by 1.
- R5: After each walk the X and Y walk steps grow by registers 6 and 7, and at every new line they return to registers 2 and 3. After each line the X and Y line steps grow by registers 8 and 9.
- R6: After the last walk of a line (u = umax, register 12) that is not the last line, the next address is the previous line's first address plus the line steps. The line steps start at registers 4 and 5. u returns to umin and v rises by 1.
- R7: `acc` is 0 on the first tap of every walk and 1 on the other taps. `init` is 1 only on the first cycle of a frame.
- R8: `end_x` is 1 on the last tap of the last walk of each line. `end_y` is 1 on every cycle of the last line (v = vmax, register 14). `done` is 1 on the final tap of the frame, and in the cycle after it `addr_vld` is 0.
- R9: A start pulse while a frame is running is ignored, and the running sequence continues unchanged.
- R10: A start pulse with a mode other than 2'b01 is ignored, and `addr_vld` stays 0.
- R11: Registers are 12-bit two's complement values written at `cfg_addr` when `cfg_we` is high. Steps are sign-extended before they are added, and addresses wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 12 | Register write data |
| start | input | 1 | One-cycle frame start request |
| addr_vld | output | 1 | Frame in progress; outputs are meaningful |
| pix_x | output | AW | Source X address |
| pix_y | output | AW | Source Y address |
| coef_addr | output | 4 | Filter tap index within the walk |
| out_u | output | 12 | Output pixel column |
| out_v | output | 12 | Output line |
| init | output | 1 | First cycle of the frame |
| acc | output | 1 | Accumulate (low restarts the sum) |
| end_x | output | 1 | Last tap of a line |
| end_y | output | 1 | Cycle belongs to the last line |
| done | output | 1 | Last tap of the frame |

## Verification
The hardest case to reach is second-order stepping combined with wrap-around. In that case the walk step changes after every walk and is reset at each line, while the line step keeps growing and the addresses cross the 12-bit boundary in both directions. The bench reaches it with one configuration that uses nonzero second-order terms in both axes and a start point near the top of the range. That configuration is swept together with the other configurations over kernel lengths 1, 2, 3 and 5 and strides 0, 1, 3 and 7. For every cycle the expected addresses come from a nested walk/line reconstruction. A start pulse injected mid-frame and starts with illegal modes cover the ignored cases.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_RW   = 12;
  localparam int unsigned RS_AXES = 2;
  localparam logic [1:0]  RS_MODE_HPASS = 2'b01;

  typedef logic [RS_RW-1:0] rs_word_t;

  typedef struct packed {
    rs_word_t [RS_AXES-1:0] start;
    rs_word_t [RS_AXES-1:0] du;
    rs_word_t [RS_AXES-1:0] dv;
    rs_word_t [RS_AXES-1:0] d2u;
    rs_word_t [RS_AXES-1:0] d2v;
    logic [1:0] mode;
    logic [3:0] ksz;
    logic [2:0] fov;
    rs_word_t umin;
    rs_word_t umax;
    rs_word_t vmin;
    rs_word_t vmax;
  } rs_cfg_t;

  // Index of the final tap of a walk for a given size field.
  function automatic logic [3:0] rs_last_tap(input logic [3:0] ksz);
    return ksz;
  endfunction

  // Next output coordinate along u or v.
  function automatic rs_word_t rs_coord_inc(input rs_word_t c);
    return c + rs_word_t'(1);
  endfunction
endpackage

// File: rtl/rs_param_bank.sv
module rs_param_bank
  import rs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  rs_word_t   wr_data,
  output rs_cfg_t    cfg
);
  logic [2:0] unused_ctrl_hi;
  assign unused_ctrl_hi = wr_data[11:9];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0:  cfg.start[0] <= wr_data;
        4'd1:  cfg.start[1] <= wr_data;
        4'd2:  cfg.du[0]    <= wr_data;
        4'd3:  cfg.du[1]    <= wr_data;
        4'd4:  cfg.dv[0]    <= wr_data;
        4'd5:  cfg.dv[1]    <= wr_data;
        4'd6:  cfg.d2u[0]   <= wr_data;
        4'd7:  cfg.d2u[1]   <= wr_data;
        4'd8:  cfg.d2v[0]   <= wr_data;
        4'd9:  cfg.d2v[1]   <= wr_data;
        4'd10: begin
          cfg.mode <= wr_data[1:0];
          cfg.ksz  <= wr_data[5:2];
          cfg.fov  <= wr_data[8:6];
        end
        4'd11: cfg.umin <= wr_data;
        4'd12: cfg.umax <= wr_data;
        4'd13: cfg.vmin <= wr_data;
        4'd14: cfg.vmax <= wr_data;
        default: ;
      endcase
    end
  end

  p_ctrl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd10) |=> (cfg.ksz == $past(wr_data[5:2]) && cfg.fov == $past(wr_data[8:6])));
  p_start_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd0) |=> (cfg.start[0] == $past(wr_data)));
endmodule

// File: rtl/rs_walk_ctl.sv
module rs_walk_ctl
  import rs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  rs_cfg_t    cfg,
  output logic [3:0] tap,
  output rs_word_t   u,
  output rs_word_t   v,
  output logic       busy,
  output logic       first,
  output logic       ev_load,
  output logic       ev_in_walk,
  output logic       ev_walk_end,
  output logic       ev_line_end,
  output logic       ev_frame_end
);
  logic last_tap, last_walk, last_line;

  assign last_tap  = (tap == rs_last_tap(cfg.ksz));
  assign last_walk = (u == cfg.umax);
  assign last_line = (v == cfg.vmax);

  assign ev_load      = start && !busy && (cfg.mode == RS_MODE_HPASS);
  assign ev_in_walk   = busy && !last_tap;
  assign ev_walk_end  = busy && last_tap && !last_walk;
  assign ev_line_end  = busy && last_tap && last_walk && !last_line;
  assign ev_frame_end = busy && last_tap && last_walk && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      first <= 1'b0;
      tap   <= '0;
      u     <= '0;
      v     <= '0;
    end else begin
      first <= ev_load;
      if (ev_load) begin
        busy <= 1'b1;
        tap  <= '0;
        u    <= cfg.umin;
        v    <= cfg.vmin;
      end else if (ev_in_walk) begin
        tap <= tap + 4'd1;
      end else if (ev_walk_end) begin
        tap <= '0;
        u   <= rs_coord_inc(u);
      end else if (ev_line_end) begin
        tap <= '0;
        u   <= cfg.umin;
        v   <= rs_coord_inc(v);
      end else if (ev_frame_end) begin
        tap  <= '0;
        busy <= 1'b0;
      end
    end
  end

  p_tap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tap <= cfg.ksz));
  p_walk_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_walk_end || ev_line_end) |=> (tap == 4'd0 && busy));
  p_init_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> !first);
  p_done_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |=> !busy);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev_frame_end) |=> busy);
endmodule

// File: rtl/rs_addr_path.sv
module rs_addr_path
  import rs_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rs_cfg_t       cfg,
  input  logic          ev_load,
  input  logic          ev_in_walk,
  input  logic          ev_walk_end,
  input  logic          ev_line_end,
  output logic [AW-1:0] pos [RS_AXES]
);
  // Sign-extend a register value to the address width.
  function automatic logic [AW-1:0] widen(input rs_word_t w);
    logic signed [AW-1:0] s;
    s = AW'($signed(w));
    return s;
  endfunction

  for (genvar a = 0; a < RS_AXES; a++) begin : g_axis
    logic [AW-1:0] cur, base, inc_u, inc_v, tap_step;

    // Only the X axis moves inside a walk in the horizontal pass.
    assign tap_step = (a == 0) ? AW'(cfg.fov) : '0;
    assign pos[a]   = cur;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur   <= '0;
        base  <= '0;
        inc_u <= '0;
        inc_v <= '0;
      end else if (ev_load) begin
        cur   <= widen(cfg.start[a]);
        base  <= widen(cfg.start[a]);
        inc_u <= widen(cfg.du[a]);
        inc_v <= widen(cfg.dv[a]);
      end else if (ev_in_walk) begin
        cur <= cur + tap_step;
      end else if (ev_walk_end) begin
        cur   <= cur + inc_u;
        inc_u <= inc_u + widen(cfg.d2u[a]);
      end else if (ev_line_end) begin
        cur   <= base + inc_v;
        base  <= base + inc_v;
        inc_v <= inc_v + widen(cfg.d2v[a]);
        inc_u <= widen(cfg.du[a]);
      end
    end

    p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load |=> (cur == base));
    p_line_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_line_end |=> (cur == base));
    if (a == 1) begin : g_ychk
      p_y_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_walk |=> (cur == $past(cur)));
    end
  end
endmodule

// File: rtl/rs_resample_seq.sv
module rs_resample_seq
  import rs_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [11:0]   cfg_wdata,
  input  logic          start,
  output logic          addr_vld,
  output logic [AW-1:0] pix_x,
  output logic [AW-1:0] pix_y,
  output logic [3:0]    coef_addr,
  output logic [11:0]   out_u,
  output logic [11:0]   out_v,
  output logic          init,
  output logic          acc,
  output logic          end_x,
  output logic          end_y,
  output logic          done
);
  rs_cfg_t       cfg;
  logic [3:0]    tap;
  rs_word_t      u, v;
  logic          busy, first;
  logic          ev_load, ev_in_walk, ev_walk_end, ev_line_end, ev_frame_end;
  logic [AW-1:0] pos [RS_AXES];

  rs_param_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .cfg(cfg)
  );

  rs_walk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg),
    .tap(tap), .u(u), .v(v), .busy(busy), .first(first),
    .ev_load(ev_load), .ev_in_walk(ev_in_walk), .ev_walk_end(ev_walk_end),
    .ev_line_end(ev_line_end), .ev_frame_end(ev_frame_end)
  );

  rs_addr_path #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .ev_load(ev_load), .ev_in_walk(ev_in_walk), .ev_walk_end(ev_walk_end),
    .ev_line_end(ev_line_end), .pos(pos)
  );

  assign addr_vld  = busy;
  assign pix_x     = pos[0];
  assign pix_y     = pos[1];
  assign coef_addr = tap;
  assign out_u     = u;
  assign out_v     = v;
  assign init      = first;
  assign acc       = busy && (tap != 4'd0);
  assign end_x     = ev_line_end || ev_frame_end;
  assign end_y     = busy && (v == cfg.vmax);
  assign done      = ev_frame_end;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |-> !(init || acc || end_x || end_y || done));
  p_mode_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !addr_vld && cfg.mode != RS_MODE_HPASS) |=> !addr_vld);
  p_init_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> (!acc && coef_addr == 4'd0));
  p_done_has_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (end_x && end_y));
endmodule

// File: tb/rs_resample_seq_tb.sv
`timescale 1ns/1ps
module rs_resample_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        addr_vld, init, acc, end_x, end_y, done;
  logic [11:0] pix_x, pix_y, out_u, out_v;
  logic [3:0]  coef_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rs_resample_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .addr_vld(addr_vld),
    .pix_x(pix_x), .pix_y(pix_y), .coef_addr(coef_addr), .out_u(out_u),
    .out_v(out_v), .init(init), .acc(acc), .end_x(end_x), .end_y(end_y),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk_idle(input string tag);
    chk(addr_vld == 1'b0, tag, "addr_vld", addr_vld, 0);
    chk({init, acc, end_x, end_y, done} == 5'b0, tag, "flags",
        {init, acc, end_x, end_y, done}, 0);
  endtask

  // Configuration registers held by the bench for its own model.
  logic [11:0] r [15];

  task automatic load_cfg();
    for (int i = 0; i < 15; i++) wr(4'(i), r[i]);
  endtask

  // Run one frame and compare every cycle against a nested reconstruction.
  task automatic run_frame();
    int k, fov, nw, nl, total, idx;
    logic [11:0] lx, ly, ivx, ivy, cx, cy, iux, iuy, ex;
    string tg;
    k   = int'(r[10][5:2]) + 1;
    fov = int'(r[10][8:6]);
    nw  = int'(r[12] - r[11]) + 1;
    nl  = int'(r[14] - r[13]) + 1;
    total = k * nw * nl;
    idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lx = r[0]; ly = r[1]; ivx = r[4]; ivy = r[5];
    for (int l = 0; l < nl; l++) begin
      cx = lx; cy = ly; iux = r[2]; iuy = r[3];
      for (int w = 0; w < nw; w++) begin
        for (int p = 0; p < k; p++) begin
          ex = cx + 12'(p * fov);
          if (p > 0) tg = "R3";
          else if (w > 0) tg = "R4/R5";
          else if (l > 0) tg = "R6/R5";
          else tg = "R2";
          chk(addr_vld == 1'b1, tg, "addr_vld", addr_vld, 1);
          chk(pix_x == ex, tg, "pix_x", pix_x, ex);
          chk(pix_y == cy, tg, "pix_y", pix_y, cy);
          chk(coef_addr == 4'(p), "R3", "coef_addr", coef_addr, p);
          chk(out_u == r[11] + 12'(w), tg, "out_u", out_u, r[11] + 12'(w));
          chk(out_v == r[13] + 12'(l), tg, "out_v", out_v, r[13] + 12'(l));
          chk(acc == (p != 0), "R7", "acc", acc, p != 0);
          chk(init == (idx == 0), "R7", "init", init, idx == 0);
          chk(end_x == (w == nw - 1 && p == k - 1), "R8", "end_x", end_x,
              w == nw - 1 && p == k - 1);
          chk(end_y == (l == nl - 1), "R8", "end_y", end_y, l == nl - 1);
          chk(done == (idx == total - 1), "R8", "done", done, idx == total - 1);
          if (idx == 3 && total > 5)
            chk(init == 1'b0 && addr_vld == 1'b1, "R9", "restart", init, 0);
          start = (idx == 2 && total > 5);
          idx++;
          @(negedge clk);
        end
        cx = cx + 12'((k - 1) * fov) + iux;
        cy = cy + iuy;
        iux = iux + r[6];
        iuy = iuy + r[7];
      end
      lx = lx + ivx; ly = ly + ivy;
      ivx = ivx + r[8]; ivy = ivy + r[9];
    end
    start = 1'b0;
    chk_idle("R8");
  endtask

  task automatic set_base(input int s);
    for (int i = 0; i < 15; i++) r[i] = '0;
    case (s)
      0: begin
        r[2] = 12'hFFF; r[5] = 12'h001;
        r[11] = 12'd5; r[12] = 12'd7; r[13] = 12'd5; r[14] = 12'd6;
      end
      1: begin
        r[0] = 12'hFF0; r[1] = 12'h010; r[2] = 12'h003; r[3] = 12'hFFE;
        r[4] = 12'hFF0; r[5] = 12'h805; r[6] = 12'h001; r[7] = 12'hFFF;
        r[8] = 12'h002; r[9] = 12'h803;
        r[11] = 12'd0; r[12] = 12'd3; r[13] = 12'd10; r[14] = 12'd12;
      end
      default: begin
        r[0] = 12'hFFE; r[1] = 12'hFFF; r[2] = 12'h002; r[3] = 12'h001;
        r[4] = 12'h001; r[5] = 12'h7FF;
        r[11] = 12'd9; r[12] = 12'd9; r[13] = 12'd4; r[14] = 12'd4;
      end
    endcase
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int ktab[4] = '{0, 1, 2, 4};
    int ftab[4] = '{0, 1, 3, 7};
    repeat (2) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    for (int s = 0; s < 3; s++)
      for (int ki = 0; ki < 4; ki++)
        for (int fi = 0; fi < 4; fi++) begin
          set_base(s);
          r[10] = {3'b000, 3'(ftab[fi]), 4'(ktab[ki]), 2'b01};
          load_cfg();
          run_frame();
        end

    // Illegal modes: start must not launch a frame.
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      set_base(0);
      r[10] = {3'b000, 3'd1, 4'd2, 2'(m)};
      load_cfg();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk_idle("R10");
        @(negedge clk);
      end
    end

    // Register write takes effect for the next frame (R11).
    set_base(0);
    r[10] = {3'b000, 3'd1, 4'd2, 2'b01};
    r[0] = 12'h800;
    load_cfg();
    run_frame();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule